// File: doc/BRIEF.md
# Pin-Change Edge Interrupt Port

This block watches eight asynchronous input pins and turns a chosen edge on any of them into a pending event. Each pin has its own edge polarity bit, its own mask bit and its own sticky pending bit. Every pin is brought into the clock domain by a two-flop synchronizer. An edge is found by comparing the synchronized level with the level one cycle earlier.

A pending bit is set by an active edge whether or not that pin is unmasked. It stays set until software writes a 1 to it. The mask only decides whether the pending bit reaches the single registered interrupt line. Software reaches the three byte-wide control registers through a small register bus. Reads return data in the same cycle. Writes take effect at the clock edge on which the bus selects a write.

Top module: `pinchg_irq_port`

## Requirements
- R1: After reset the polarity, enable and pending registers all read 0x00 and `irq_o` is 0.
- R2: Register offsets are: polarity at 0x1D, enable at 0x1E, pending at 0x1F. In each register, bit n belongs to pin n. Reads are combinational and allowed at any time. Any other offset reads 0x00, and writes to other offsets change nothing.
- R3: A polarity bit of 1 selects rising edges for its pin and 0 selects falling edges. An edge of the opposite direction leaves the pending bit unchanged.
- R4: A pin change driven before clock edge k shows in the pending register after edge k+2 (two synchronizer stages plus the pending flop). It is not yet visible after edge k+1.
- R5: Writing 1 to a pending bit clears it. Writing 0 leaves it as it is.
- R6: A pending bit sets even while its enable bit is 0. While masked, it does not drive `irq_o`.
- R7: Setting an enable bit while its pending bit is already set raises `irq_o` one clock after the enable write takes effect.
- R8: When an active edge and a write-1 clear reach the same pending bit in the same cycle, the bit ends up set. Other bits cleared by that same write still clear.
- R9: `irq_o` is the OR over all pins of (pending AND enable), registered, so it follows the register state with one cycle of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 8 | Asynchronous port pins |
| bus_sel | input | 1 | Register bus select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 5 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Two functions can fall in the same cycle: a new active edge setting a pending bit, and a software write-1 clearing that same bit. The bench provokes this by toggling a pin and timing a bus write to the pending register so that it lands exactly on the clock edge where the synchronized edge is detected. That write also targets a second bit that has no new edge. The expected result is that the edge bit survives and the other bit clears, which the bench confirms by reading the pending register afterwards.

// File: rtl/pinchg_irq_port.sv
module pinchg_irq_port #(
  parameter int NPINS = 8,
  parameter int AW = 5,
  parameter logic [AW-1:0] OFS_POL  = 5'h1D,
  parameter logic [AW-1:0] OFS_EN   = 5'h1E,
  parameter logic [AW-1:0] OFS_FLAG = 5'h1F
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_i,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [AW-1:0]    bus_addr,
  input  logic [NPINS-1:0] bus_wdata,
  output logic [NPINS-1:0] bus_rdata,
  output logic             irq_o
);

  logic [NPINS-1:0] sync1, sync2, last;
  logic [NPINS-1:0] pol_q, en_q, flag_q;
  logic [NPINS-1:0] edge_hit, clr_mask;
  logic             irq_q;
  logic             wr_pol, wr_en, wr_flag;

  assign wr_pol  = bus_sel & bus_wr & (bus_addr == OFS_POL);
  assign wr_en   = bus_sel & bus_wr & (bus_addr == OFS_EN);
  assign wr_flag = bus_sel & bus_wr & (bus_addr == OFS_FLAG);

  assign edge_hit = (pol_q & sync2 & ~last) | (~pol_q & ~sync2 & last);
  assign clr_mask = wr_flag ? bus_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      last  <= '0;
    end else begin
      sync1 <= pin_i;
      sync2 <= sync1;
      last  <= sync2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q  <= '0;
      en_q   <= '0;
      flag_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (wr_pol) pol_q <= bus_wdata;
      if (wr_en)  en_q  <= bus_wdata;
      flag_q <= (flag_q & ~clr_mask) | edge_hit;
      irq_q  <= |(flag_q & en_q);
    end
  end

  always_comb begin
    case (bus_addr)
      OFS_POL:  bus_rdata = pol_q;
      OFS_EN:   bus_rdata = en_q;
      OFS_FLAG: bus_rdata = flag_q;
      default:  bus_rdata = '0;
    endcase
  end

  assign irq_o = irq_q;

  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(wr_flag)) |-> ((flag_q & $past(flag_q)) == $past(flag_q)));

  assert_w1c_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(wr_flag)) |-> ((flag_q & $past(bus_wdata) & ~$past(edge_hit)) == '0));

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> ((flag_q & $past(edge_hit)) == $past(edge_hit)));

  assert_irq_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (irq_o == |($past(flag_q) & $past(en_q))));

  assert_masked_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(en_q) == '0) |-> !irq_o);

endmodule

// File: tb/pinchg_irq_port_tb.sv
module pinchg_irq_port_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] A_POL = 5'h1D, A_EN = 5'h1E, A_FLAG = 5'h1F;
  // pol, en, pins before, pins after, expected pending, expected irq
  localparam logic [40:0] VEC [7] = '{
    {8'h00, 8'hFF, 8'hFF, 8'h00, 8'hFF, 1'b1},
    {8'hFF, 8'hFF, 8'h00, 8'hFF, 8'hFF, 1'b1},
    {8'hFF, 8'hFF, 8'hFF, 8'h00, 8'h00, 1'b0},
    {8'h0F, 8'hF0, 8'hA5, 8'h5A, 8'hAA, 1'b1},
    {8'hF0, 8'h0F, 8'h0F, 8'hF0, 8'hFF, 1'b1},
    {8'hAA, 8'h01, 8'h00, 8'hFF, 8'hAA, 1'b0},
    {8'h55, 8'h55, 8'hFF, 8'h00, 8'hAA, 1'b0}
  };

  logic clk = 0, rst_n = 0;
  logic [7:0] pin_i = '0, bus_wdata = '0, bus_rdata;
  logic bus_sel = 0, bus_wr = 0, irq_o;
  logic [4:0] bus_addr = '0;
  int n_run = 0, n_fail = 0;
  logic [7:0] rd;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pinchg_irq_port dut_i (.clk(clk), .rst_n(rst_n), .pin_i(pin_i), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o));

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rdreg(logic [4:0] a, output logic [7:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rdreg(A_POL, rd);  check("R1 pol reset", rd, 8'h00);
    rdreg(A_EN, rd);   check("R1 en reset", rd, 8'h00);
    rdreg(A_FLAG, rd); check("R1 flag reset", rd, 8'h00);
    check("R1 irq reset", {7'b0, irq_o}, 8'h00);

    wr(5'h00, 8'hFF);
    rdreg(5'h00, rd); check("R2 unmapped reads zero", rd, 8'h00);
    rdreg(A_POL, rd); check("R2 unmapped write ignored", rd, 8'h00);
    wr(A_POL, 8'h3C);
    rdreg(A_POL, rd); check("R2 pol readback", rd, 8'h3C);

    for (int i = 0; i < 7; i++) begin
      wr(A_POL, VEC[i][40:33]);
      pin_i = VEC[i][24:17];
      idle(5);
      wr(A_FLAG, 8'hFF);
      wr(A_EN, VEC[i][32:25]);
      rdreg(A_FLAG, rd); check("R5 cleared before vector", rd, 8'h00);
      pin_i = VEC[i][16:9];
      idle(5);
      rdreg(A_FLAG, rd); check("R3 pending per polarity", rd, VEC[i][8:1]);
      check("R9 irq per vector", {7'b0, irq_o}, {7'b0, VEC[i][0]});
    end

    // R4 latency, R6 masked set
    wr(A_EN, 8'h00); wr(A_POL, 8'hFF); pin_i = 8'h00; idle(5); wr(A_FLAG, 8'hFF);
    @(negedge clk); pin_i = 8'h01;
    @(negedge clk); rdreg(A_FLAG, rd); check("R4 not after k", rd, 8'h00);
    @(negedge clk); rdreg(A_FLAG, rd); check("R4 not after k+1", rd, 8'h00);
    @(negedge clk); rdreg(A_FLAG, rd); check("R4 set after k+2", rd, 8'h01);
    idle(2);
    check("R6 masked irq low", {7'b0, irq_o}, 8'h00);

    // R7 enable with pending flag
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = A_EN; bus_wdata = 8'h01;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
    check("R7 irq not yet", {7'b0, irq_o}, 8'h00);
    @(negedge clk); check("R7 irq raised", {7'b0, irq_o}, 8'h01);
    wr(A_EN, 8'h00); idle(2);

    // R5 write 0 no effect, write 1 clears
    pin_i = 8'h0F; idle(5);
    rdreg(A_FLAG, rd); check("R3 rising on new pins", rd, 8'h0F);
    wr(A_FLAG, 8'hF0);
    rdreg(A_FLAG, rd); check("R5 write zero ignored", rd, 8'h0F);
    wr(A_FLAG, 8'h0C);
    rdreg(A_FLAG, rd); check("R5 write one clears", rd, 8'h03);

    // R8 set wins over clear
    pin_i = 8'h0E; idle(5);
    rdreg(A_FLAG, rd); check("R3 falling ignored", rd, 8'h03);
    @(negedge clk); pin_i = 8'h0F;
    @(negedge clk);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = A_FLAG; bus_wdata = 8'h03;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
    rdreg(A_FLAG, rd); check("R8 set wins, other clears", rd, 8'h01);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule